// File: doc/BRIEF.md
# Per-Load Stride Prefetcher

This block sits beside the data cache and watches every load as it happens. Each observed load gives the address of the load instruction and the data address it reads. A small direct-mapped table holds one entry per load instruction. The entry is selected by the low instruction-address bits and checked against the remaining high bits. Each entry records the previous data address, the difference between consecutive data addresses (the stride), and a three-state confidence code.

An entry first sees an allocation, then a learned stride, then a confirming access. After that it becomes steady. In steady state every access whose stride matches the stored one issues a prefetch request for the current address plus the stride. Because strides are kept per load instruction, large and negative strides are followed as easily as sequential lines. The request is presented on a valid/ready output that holds a single pending request, and a newer request replaces an older one that has not yet been taken. The load side is never stalled.

Top module: `stride_pf`

## Requirements
- R1: While `rst_n` is low, `pf_valid` is 0 and every table entry is invalid. A load instruction that had reached steady state before a reset issues no prefetch on its first access after the reset.
- R2: A load whose entry is missing or invalid allocates an entry that holds only the data address, and issues no prefetch. The next access by the same load stores the stride (current minus previous data address) and issues no prefetch.
- R3: The third access with the same stride puts the entry in steady state. `pf_valid` is 1 in the cycle after that access is sampled, with `pf_addr` equal to the current data address plus the stride.
- R4: In steady state, each further access with the matching stride issues a new prefetch for its own address plus the stride.
- R5: An access whose stride differs from the stored stride issues no prefetch and replaces the stored stride. One following access that repeats the new stride issues a prefetch again.
- R6: The previous-address field is rewritten on every access by a load, in every state. Strides are therefore always measured from the most recent access.
- R7: The table is indexed by instruction-address bits [5:2] and tagged with bits [31:6]. An access whose tag differs from the stored tag replaces the entry and restarts it from allocation. Two load instructions that share an index and alternate never prefetch.
- R8: Load instructions that map to different indices learn and prefetch independently, even when their accesses are interleaved.
- R9: A stride of zero never issues a prefetch, in any state.
- R10: With 64-byte lines, data address bits [31:6], a prefetch whose address lies in the same line as the current access is suppressed.
- R11: While `pf_valid` is 1 and `pf_ready` is 0, the request is held. A new prefetch overwrites `pf_addr`. When `pf_ready` is 1 and no new prefetch arrives, `pf_valid` falls after that cycle.
- R12: Strides are two's-complement differences modulo 2^32, so descending address streams are learned and prefetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_pc | input | 32 | Instruction address of the load |
| ld_addr | input | 32 | Data address of the load |
| pf_valid | output | 1 | A prefetch request is pending |
| pf_ready | input | 1 | The consumer takes the pending request this cycle |
| pf_addr | output | 32 | Address of the pending prefetch request |

## Verification
The hardest case to reach from the ports is a steady entry whose stride changes, mixed with an aliasing load that evicts it and an output that is backpressured at the same time. That case needs several load instructions interleaved over many accesses, with `pf_ready` toggling independently. The stimulus first walks a fixed trace with hand-worked expectations. It covers learning, relearning, aliasing, zero and same-line strides, negative strides and held requests. It then drives a long pseudo-random trace from four instruction addresses, two of which share an index, with occasional stride changes and random readiness. Every cycle of that trace is compared against a behavioural table model kept in the bench.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2
  } sp_state_e;
endpackage

// File: rtl/stride_pf_rst_sync.sv
module stride_pf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_last,
  input  logic [ADDR_W-1:0] wr_stride,
  input  sp_state_e         wr_state,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_stride,
  output sp_state_e         rd_state
);
  localparam int ENTRIES = 1 << IDX_W;

  logic              vld_a    [ENTRIES];
  logic [TAG_W-1:0]  tag_a    [ENTRIES];
  logic [ADDR_W-1:0] last_a   [ENTRIES];
  logic [ADDR_W-1:0] stride_a [ENTRIES];
  sp_state_e         state_a  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              we;
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] stride_q;
    sp_state_e         state_q;

    assign we = wr_en && (idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q    <= 1'b0;
        tag_q    <= '0;
        last_q   <= '0;
        stride_q <= '0;
        state_q  <= ST_INIT;
      end else if (we) begin
        vld_q    <= 1'b1;
        tag_q    <= wr_tag;
        last_q   <= wr_last;
        stride_q <= wr_stride;
        state_q  <= wr_state;
      end
    end

    assign vld_a[e]    = vld_q;
    assign tag_a[e]    = tag_q;
    assign last_a[e]   = last_q;
    assign stride_a[e] = stride_q;
    assign state_a[e]  = state_q;
  end

  assign rd_valid  = vld_a[idx];
  assign rd_tag    = tag_a[idx];
  assign rd_last   = last_a[idx];
  assign rd_stride = stride_a[idx];
  assign rd_state  = state_a[idx];
endmodule

// File: rtl/stride_pf_update.sv
module stride_pf_update
  import stride_pf_pkg::*;
#(
  parameter int TAG_W    = 26,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6
) (
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_last,
  input  logic [ADDR_W-1:0] rd_stride,
  input  sp_state_e         rd_state,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] wr_last,
  output logic [ADDR_W-1:0] wr_stride,
  output sp_state_e         wr_state,
  output logic              cand_v,
  output logic [ADDR_W-1:0] cand_addr
);
  logic              hit;
  logic              confirm;
  logic [ADDR_W-1:0] delta;
  logic              same_line;

  assign hit   = rd_valid && (rd_tag == ld_tag);
  assign delta = ld_addr - rd_last;

  always_comb begin
    wr_en     = ld_valid;
    wr_tag    = ld_tag;
    wr_last   = ld_addr;
    wr_stride = rd_stride;
    wr_state  = rd_state;
    confirm   = 1'b0;
    if (!hit) begin
      wr_stride = '0;
      wr_state  = ST_INIT;
    end else begin
      unique case (rd_state)
        ST_TRANS, ST_STEADY: begin
          if (delta == rd_stride) begin
            wr_state = ST_STEADY;
            confirm  = 1'b1;
          end else begin
            wr_state  = ST_TRANS;
            wr_stride = delta;
          end
        end
        default: begin
          wr_state  = ST_TRANS;
          wr_stride = delta;
        end
      endcase
    end
  end

  assign cand_addr = ld_addr + rd_stride;
  assign same_line = cand_addr[ADDR_W-1:LINE_OFF] == ld_addr[ADDR_W-1:LINE_OFF];
  assign cand_v    = ld_valid && confirm && (rd_stride != '0) && !same_line;
endmodule

// File: rtl/stride_pf_issue.sv
module stride_pf_issue #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_v,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  logic              valid_d;
  logic              addr_en;

  always_comb begin
    addr_en = cand_v;
    if (cand_v)        valid_d = 1'b1;
    else if (pf_ready) valid_d = 1'b0;
    else               valid_d = pf_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_valid <= 1'b0;
    else        pf_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pf_addr <= '0;
    else if (addr_en) pf_addr <= cand_addr;
  end
endmodule

// File: rtl/stride_pf.sv
module stride_pf
  import stride_pf_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int PC_LSB   = 2,
  parameter int LINE_OFF = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int TAG_LSB = PC_LSB + IDX_W;
  localparam int TAG_W   = PC_W - TAG_LSB;

  logic              rst_int_n;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              unused_pc_low;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_last;
  logic [ADDR_W-1:0] rd_stride;
  sp_state_e         rd_state;

  logic              wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [ADDR_W-1:0] wr_last;
  logic [ADDR_W-1:0] wr_stride;
  sp_state_e         wr_state;

  logic              cand_v;
  logic [ADDR_W-1:0] cand_addr;

  assign idx           = ld_pc[TAG_LSB-1:PC_LSB];
  assign tag           = ld_pc[PC_W-1:TAG_LSB];
  assign unused_pc_low = ^ld_pc[PC_LSB-1:0];

  stride_pf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  stride_pf_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .idx       (idx),
    .wr_en     (wr_en),
    .wr_tag    (wr_tag),
    .wr_last   (wr_last),
    .wr_stride (wr_stride),
    .wr_state  (wr_state),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_last   (rd_last),
    .rd_stride (rd_stride),
    .rd_state  (rd_state)
  );

  stride_pf_update #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_update (
    .ld_valid  (ld_valid),
    .ld_tag    (tag),
    .ld_addr   (ld_addr),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_last   (rd_last),
    .rd_stride (rd_stride),
    .rd_state  (rd_state),
    .wr_en     (wr_en),
    .wr_tag    (wr_tag),
    .wr_last   (wr_last),
    .wr_stride (wr_stride),
    .wr_state  (wr_state),
    .cand_v    (cand_v),
    .cand_addr (cand_addr)
  );

  stride_pf_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cand_v    (cand_v),
    .cand_addr (cand_addr),
    .pf_ready  (pf_ready),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr)
  );
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R11
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && pf_valid && !pf_ready |=> pf_valid);

  // R11
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && pf_valid && pf_ready && !ld_valid |=> !pf_valid);

  // R2
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !ld_valid |=> $stable(pf_addr));

  // R10
  line_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && pf_valid && $past(ld_valid) && (pf_addr != $past(pf_addr))
    |-> pf_addr[ADDR_W-1:LINE_OFF] != $past(ld_addr[ADDR_W-1:LINE_OFF]));

  // R9
  zero_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && pf_valid && $past(ld_valid) && (pf_addr != $past(pf_addr))
    |-> pf_addr != $past(ld_addr));
endmodule

bind stride_pf stride_pf_chk #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ld_valid (ld_valid),
  .ld_addr  (ld_addr),
  .pf_valid (pf_valid),
  .pf_ready (pf_ready),
  .pf_addr  (pf_addr)
);

// File: tb/stride_pf_tb_top.sv
`timescale 1ns/1ps
module stride_pf_tb_top;
  logic        clk;
  logic        rst_n;
  logic        ld_valid;
  logic [31:0] ld_pc;
  logic [31:0] ld_addr;
  logic        pf_valid;
  logic        pf_ready;
  logic [31:0] pf_addr;

  int nvec;
  int nerr;

  stride_pf dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_pc    (ld_pc),
    .ld_addr  (ld_addr),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_addr  (pf_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model of the table and output stage
  logic        m_v      [16];
  logic [25:0] m_tag    [16];
  logic [31:0] m_last   [16];
  logic [31:0] m_stride [16];
  int          m_st     [16];
  logic        m_pfv;
  logic [31:0] m_pfa;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 1'b0; m_st[i] = 0; m_stride[i] = '0; m_last[i] = '0; m_tag[i] = '0;
    end
    m_pfv = 1'b0;
    m_pfa = '0;
  endtask

  task automatic model_step(input logic lv, input logic [31:0] pc, input logic [31:0] a,
                            input logic rdy);
    int          ix;
    logic [31:0] d;
    logic        cv;
    logic [31:0] ca;
    ix = int'(pc[5:2]);
    cv = 1'b0;
    ca = '0;
    if (lv) begin
      if (!m_v[ix] || m_tag[ix] != pc[31:6]) begin
        m_v[ix] = 1'b1; m_tag[ix] = pc[31:6]; m_stride[ix] = '0; m_st[ix] = 0;
      end else begin
        d = a - m_last[ix];
        if (m_st[ix] == 0) begin
          m_stride[ix] = d; m_st[ix] = 1;
        end else if (d == m_stride[ix]) begin
          m_st[ix] = 2;
          if (d != 0 && ((a + d) >> 6) != (a >> 6)) begin
            cv = 1'b1; ca = a + d;
          end
        end else begin
          m_stride[ix] = d; m_st[ix] = 1;
        end
      end
      m_last[ix] = a;
    end
    if (cv) begin
      m_pfv = 1'b1; m_pfa = ca;
    end else if (rdy) begin
      m_pfv = 1'b0;
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic apply(input int req, input logic lv, input logic [31:0] pc,
                       input logic [31:0] a, input logic rdy,
                       input logic use_exp, input logic expv);
    logic bad;
    ld_valid = lv; ld_pc = pc; ld_addr = a; pf_ready = rdy;
    model_step(lv, pc, a, rdy);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    nvec++;
    bad = (pf_valid !== m_pfv) || (m_pfv && pf_addr !== m_pfa) || (use_exp && pf_valid !== expv);
    if (bad) begin
      nerr++;
      $display("FAIL R%0d step %0d: actual valid=%b addr=%h expected valid=%b addr=%h",
               req, nvec, pf_valid, pf_addr, (use_exp ? expv : m_pfv), m_pfa);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        lv;
    logic [31:0] pc;
    logic [31:0] addr;
    logic        rdy;
    logic        expv;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 32'h100, 32'h1000, 1'b1, 1'b0}, // R2 allocate
    '{4'd2,  1'b1, 32'h100, 32'h1100, 1'b1, 1'b0}, // R2 learn stride 0x100
    '{4'd3,  1'b1, 32'h100, 32'h1200, 1'b1, 1'b1}, // R3 confirm, prefetch 1300
    '{4'd4,  1'b1, 32'h100, 32'h1300, 1'b1, 1'b1}, // R4 prefetch 1400
    '{4'd11, 1'b0, 32'h0,   32'h0,    1'b1, 1'b0}, // R11 taken, drops
    '{4'd5,  1'b1, 32'h100, 32'h1340, 1'b1, 1'b0}, // R5 R6 mismatch from last 1300
    '{4'd5,  1'b1, 32'h100, 32'h1380, 1'b1, 1'b1}, // R5 new stride 0x40 confirmed
    '{4'd8,  1'b1, 32'h104, 32'h2000, 1'b1, 1'b0}, // R8 second load allocates
    '{4'd8,  1'b1, 32'h100, 32'h13C0, 1'b1, 1'b1}, // R8 first load still steady
    '{4'd12, 1'b1, 32'h104, 32'h1FF0, 1'b1, 1'b0}, // R12 stride -0x10 learned
    '{4'd10, 1'b1, 32'h104, 32'h1FE0, 1'b1, 1'b0}, // R10 1FD0 same line, suppressed
    '{4'd12, 1'b1, 32'h104, 32'h1FA0, 1'b1, 1'b0}, // R12 stride -0x40 relearned
    '{4'd12, 1'b1, 32'h104, 32'h1F60, 1'b1, 1'b1}, // R12 prefetch 1F20
    '{4'd7,  1'b1, 32'h140, 32'h5000, 1'b1, 1'b0}, // R7 alias evicts
    '{4'd7,  1'b1, 32'h100, 32'h1400, 1'b1, 1'b0}, // R7 evicted, restarts
    '{4'd7,  1'b1, 32'h140, 32'h5100, 1'b1, 1'b0}, // R7
    '{4'd7,  1'b1, 32'h100, 32'h1500, 1'b1, 1'b0}, // R7
    '{4'd9,  1'b1, 32'h108, 32'h3000, 1'b1, 1'b0}, // R9 allocate
    '{4'd9,  1'b1, 32'h108, 32'h3000, 1'b1, 1'b0}, // R9 zero stride
    '{4'd9,  1'b1, 32'h108, 32'h3000, 1'b1, 1'b0}, // R9 steady, zero
    '{4'd9,  1'b1, 32'h108, 32'h3000, 1'b1, 1'b0}, // R9
    '{4'd11, 1'b1, 32'h10C, 32'h4000, 1'b1, 1'b0}, // R11 setup
    '{4'd11, 1'b1, 32'h10C, 32'h4200, 1'b1, 1'b0}, // R11 setup
    '{4'd11, 1'b1, 32'h10C, 32'h4400, 1'b0, 1'b1}, // R11 prefetch 4600, not taken
    '{4'd11, 1'b0, 32'h0,   32'h0,    1'b0, 1'b1}, // R11 held
    '{4'd11, 1'b1, 32'h10C, 32'h4600, 1'b0, 1'b1}, // R11 overwritten by 4800
    '{4'd11, 1'b0, 32'h0,   32'h0,    1'b1, 1'b0}  // R11 taken, drops
  };

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual 200000 cycles, expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] cur  [4];
    logic [31:0] strd [4];
    logic [31:0] pcs  [4];
    nvec = 0; nerr = 0;
    ld_valid = 1'b0; ld_pc = '0; ld_addr = '0; pf_ready = 1'b1;
    model_reset();
    do_reset();

    // R1 reset state
    nvec++;
    if (pf_valid !== 1'b0) begin
      nerr++;
      $display("FAIL R1 after reset: actual valid=%b expected valid=0", pf_valid);
    end

    for (int i = 0; i < NV; i++)
      apply(int'(VECS[i].req), VECS[i].lv, VECS[i].pc, VECS[i].addr, VECS[i].rdy, 1'b1,
            VECS[i].expv);

    // R1: steady entry with a held request, then reset clears both
    apply(1, 1'b1, 32'h110, 32'h6000, 1'b0, 1'b1, 1'b0);
    apply(1, 1'b1, 32'h110, 32'h6100, 1'b0, 1'b1, 1'b0);
    apply(1, 1'b1, 32'h110, 32'h6200, 1'b0, 1'b1, 1'b1);
    do_reset();
    nvec++;
    if (pf_valid !== 1'b0) begin
      nerr++;
      $display("FAIL R1 pending after reset: actual valid=%b expected valid=0", pf_valid);
    end
    apply(1, 1'b1, 32'h110, 32'h6300, 1'b1, 1'b1, 1'b0);
    apply(1, 1'b1, 32'h110, 32'h6400, 1'b1, 1'b1, 1'b0);

    // R8 R7 R5 R11: interleaved pseudo-random trace against the model
    pcs[0] = 32'h200; pcs[1] = 32'h204; pcs[2] = 32'h240; pcs[3] = 32'h208;
    for (int k = 0; k < 4; k++) begin
      cur[k]  = 32'h10000 * (k + 1);
      strd[k] = 32'h40 * (k + 1);
    end
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int          p;
      logic        lv;
      logic        rdy;
      logic signed [7:0] sr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p   = int'(lfsr[1:0]);
      lv  = lfsr[4:2] != 3'd0;
      rdy = lfsr[6:5] != 2'd0;
      if (lfsr[11:8] == 4'd0) begin
        sr      = signed'(lfsr[15:8]);
        strd[p] = 32'(signed'(sr)) <<< 3;
      end
      if (lv) cur[p] = cur[p] + strd[p];
      apply(8, lv, pcs[p], cur[p], rdy, 1'b0, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule